// File: doc/BRIEF.md
# Clause 22 MDIO Management Master

This block lets software on a register bus reach the management registers of external Ethernet PHYs over a two-wire MDIO link. A single write to the command word carries the operation, PHY address, register number and, for writes, the data. That write launches a complete clause 22 frame: 32 preamble ones, the start pattern, the opcode, both addresses, the turnaround and sixteen data bits. All fields go out most significant bit first. The same word, read back, shows whether a frame is still running, whether a read has produced data, and the data itself.

MDC is made by dividing the system clock with a programmable half-period count. MDIO changes only after a falling MDC edge. For reads the master releases the line through the turnaround and data bits and samples the PHY on each rising MDC edge. Every completed frame raises a sticky done flag in a cause register. When the matching bit in a mask register is set, that flag drives the interrupt output. Software clears the flag by writing a word with a zero in its position.

Top module: `mdio_mgmt_master`

## Requirements
- R1: After reset the command word (offset 0x00), the cause register (0x7C) and the mask register (0x80) read as zero. The divider register (0x04, bits 7:0) reads the DIV_RST parameter. MDC, the output enable and the interrupt are all low.
- R2: A write to offset 0x00 while idle starts a frame, and bit 28 (busy) reads 1 from the next cycle until the frame ends.
- R3: Command fields are: data in bits 15:0, PHY address in bits 20:16, register number in bits 25:21, and bit 26 set for read or clear for write. A write frame drives all 64 bits with the output enable high: 32 ones, 01, 01, PHY address, register number, 10, data.
- R4: A read frame drives 32 ones, 01, 10, PHY address and register number. The output enable is low for the last 18 bits (turnaround and data), and data is taken from mdio_i on rising MDC edges.
- R5: When a read ends, bit 27 (read-valid) reads 1 and bits 15:0 hold the 16 sampled bits. When a write ends, bit 27 reads 0 and bits 15:0 hold the written data. Read-valid goes back to 0 as soon as a new command is accepted.
- R6: MDC idles low. During a frame each MDC high phase and low phase lasts max(D,1) system clocks, where D is the divider register value. A frame gives exactly 64 rising MDC edges.
- R7: A write to offset 0x00 while busy has no effect on the frame in progress or on the command word.
- R8: A finished frame sets bit 4 of the cause register. Writing a word with bit 4 at 0 clears it, and writing bit 4 as 1 leaves it unchanged.
- R9: Bit 4 of the mask register (offset 0x80) is read/write. irq is high exactly when cause bit 4 and mask bit 4 are both set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| mdc | output | 1 | Management clock to the PHYs |
| mdio_o | output | 1 | MDIO value driven by the master |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO value seen on the line |
| irq | output | 1 | Masked completion interrupt |

## Verification
The assertions assume the divider register is written only while no frame is running, so an MDC phase is never cut short in mid-count. They also assume mdio_i is settled before each rising MDC edge. The stimulus changes the divider only between transactions. The PHY model updates mdio_i only on falling MDC edges, so the line is stable for a full half period before the master samples it. Commands come from a single bench process, and the busy-overlap case issues its overlapping command on purpose.

// File: rtl/mdio_pkg.sv
`timescale 1ns/1ps
// Shared constants and types for the MDIO management master.
// Assumes a 32-bit register bus with byte offsets.
package mdio_pkg;
    localparam int REG_W      = 32;
    localparam int ADDR_W     = 8;
    localparam int FIELD_W    = 5;
    localparam int DATA_W     = 16;
    localparam int PREAMBLE_N = 32;
    localparam int FRAME_LEN  = PREAMBLE_N + 2 + 2 + 2*FIELD_W + 2 + DATA_W;
    localparam int IDX_W      = $clog2(FRAME_LEN);

    // command word field positions
    localparam int POS_DATA = 0;
    localparam int POS_PHY  = 16;
    localparam int POS_REG  = 21;
    localparam int POS_OP   = 26;
    localparam int POS_RVLD = 27;
    localparam int POS_BUSY = 28;
    localparam int POS_DONE = 4;

    localparam logic [ADDR_W-1:0] OFS_CMD   = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_DIV   = 8'h04;
    localparam logic [ADDR_W-1:0] OFS_CAUSE = 8'h7C;
    localparam logic [ADDR_W-1:0] OFS_MASK  = 8'h80;

    // frame bit indices where the read release and read sampling begin
    localparam logic [IDX_W-1:0] IDX_TA   = IDX_W'(FRAME_LEN - DATA_W - 2);
    localparam logic [IDX_W-1:0] IDX_DATA = IDX_W'(FRAME_LEN - DATA_W);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(FRAME_LEN - 1);

    typedef struct packed {
        logic               rd;
        logic [FIELD_W-1:0] phy;
        logic [FIELD_W-1:0] regn;
        logic [DATA_W-1:0]  data;
    } mdio_cmd_t;
endpackage

// File: rtl/mdio_clkgen.sv
`timescale 1ns/1ps
// MDC generator: divides clk by a half-period count while run is high.
// Assumes half stays constant while run is high; zero is treated as one.
// MDC idles low; rise_tick/fall_tick flag the cycle whose edge toggles MDC.
module mdio_clkgen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] half,
    output logic             mdc,
    output logic             rise_tick,
    output logic             fall_tick
);
    logic [DIV_W-1:0] cnt_q;
    logic [DIV_W-1:0] half_eff;
    logic             wrap;

    // clamp a zero divider to the fastest legal setting
    assign half_eff  = (half == '0) ? DIV_W'(1) : half;
    assign wrap      = run && (cnt_q == half_eff - 1'b1);
    assign rise_tick = wrap && !mdc;
    assign fall_tick = wrap && mdc;

    // half-period counter and MDC toggle
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt_q <= '0;
            mdc   <= 1'b0;
        end else if (wrap) begin
            cnt_q <= '0;
            mdc   <= ~mdc;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/mdio_shifter.sv
`timescale 1ns/1ps
// Frame serialiser: loads a full clause 22 frame, shifts it out one bit
// per MDC period (advancing on falling edges) and, for reads, releases the
// line from the turnaround onward and samples data on rising edges.
// Assumes load only arrives while active is low.
module mdio_shifter
    import mdio_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  mdio_cmd_t         cmd,
    input  logic              rise_tick,
    input  logic              fall_tick,
    input  logic              mdio_i,
    output logic              mdio_o,
    output logic              mdio_oe,
    output logic              active,
    output logic              done,
    output logic [DATA_W-1:0] rd_bits
);
    logic [FRAME_LEN-1:0] sh_q;
    logic [FRAME_LEN-1:0] frame_w;
    logic [IDX_W-1:0]     idx_q;
    logic                 is_rd_q;

    // assemble the frame image: preamble, start, opcode, addresses, TA, data
    assign frame_w = {{PREAMBLE_N{1'b1}}, 2'b01,
                      (cmd.rd ? 2'b10 : 2'b01),
                      cmd.phy, cmd.regn, 2'b10,
                      (cmd.rd ? {DATA_W{1'b0}} : cmd.data)};

    assign mdio_o  = sh_q[FRAME_LEN-1];
    assign mdio_oe = active && !(is_rd_q && idx_q >= IDX_TA);
    assign done    = active && fall_tick && (idx_q == IDX_LAST);

    // frame shift register and bit index
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q    <= '0;
            idx_q   <= '0;
            is_rd_q <= 1'b0;
            active  <= 1'b0;
        end else if (load) begin
            sh_q    <= frame_w;
            idx_q   <= '0;
            is_rd_q <= cmd.rd;
            active  <= 1'b1;
        end else if (active && fall_tick) begin
            sh_q <= {sh_q[FRAME_LEN-2:0], 1'b0};
            if (idx_q == IDX_LAST) begin
                active <= 1'b0;
            end else begin
                idx_q <= idx_q + 1'b1;
            end
        end
    end

    // read data capture on rising MDC during the data bits
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_bits <= '0;
        end else if (active && rise_tick && is_rd_q && idx_q >= IDX_DATA) begin
            rd_bits <= {rd_bits[DATA_W-2:0], mdio_i};
        end
    end
endmodule

// File: rtl/mdio_regs.sv
`timescale 1ns/1ps
// Register file: command/status word, MDC divider, done cause and mask.
// Assumes one bus write per cycle; reads are combinational on reg_addr.
module mdio_regs
    import mdio_pkg::*;
#(
    parameter int               DIV_W   = 8,
    parameter logic [DIV_W-1:0] DIV_RST = 8'd4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic              busy,
    input  logic              done,
    input  logic [DATA_W-1:0] rd_bits,
    output logic              accept,
    output mdio_cmd_t         cmd,
    output logic [DIV_W-1:0]  half,
    output logic              cause_bit,
    output logic              mask_bit,
    output logic              irq
);
    logic rvalid_q;
    logic unused_wbits;

    assign unused_wbits = ^reg_wdata[REG_W-1:POS_OP+1];
    assign accept       = reg_wr && (reg_addr == OFS_CMD) && !busy;
    assign irq          = cause_bit && mask_bit;

    // command fields, read result and read-valid flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd      <= '0;
            rvalid_q <= 1'b0;
        end else if (accept) begin
            cmd.rd   <= reg_wdata[POS_OP];
            cmd.phy  <= reg_wdata[POS_PHY +: FIELD_W];
            cmd.regn <= reg_wdata[POS_REG +: FIELD_W];
            cmd.data <= reg_wdata[POS_DATA +: DATA_W];
            rvalid_q <= 1'b0;
        end else if (done && cmd.rd) begin
            cmd.data <= rd_bits;
            rvalid_q <= 1'b1;
        end
    end

    // divider and mask registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            half     <= DIV_RST;
            mask_bit <= 1'b0;
        end else if (reg_wr) begin
            if (reg_addr == OFS_DIV)  half     <= reg_wdata[DIV_W-1:0];
            if (reg_addr == OFS_MASK) mask_bit <= reg_wdata[POS_DONE];
        end
    end

    // sticky done cause: set wins over a clear in the same cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cause_bit <= 1'b0;
        end else if (done) begin
            cause_bit <= 1'b1;
        end else if (reg_wr && reg_addr == OFS_CAUSE && !reg_wdata[POS_DONE]) begin
            cause_bit <= 1'b0;
        end
    end

    // read-back multiplexer
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            OFS_CMD: begin
                reg_rdata[POS_DATA +: DATA_W] = cmd.data;
                reg_rdata[POS_PHY +: FIELD_W] = cmd.phy;
                reg_rdata[POS_REG +: FIELD_W] = cmd.regn;
                reg_rdata[POS_OP]             = cmd.rd;
                reg_rdata[POS_RVLD]           = rvalid_q;
                reg_rdata[POS_BUSY]           = busy;
            end
            OFS_DIV:   reg_rdata[DIV_W-1:0] = half;
            OFS_CAUSE: reg_rdata[POS_DONE]  = cause_bit;
            OFS_MASK:  reg_rdata[POS_DONE]  = mask_bit;
            default:   reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/mdio_mgmt_master.sv
`timescale 1ns/1ps
// Clause 22 MDIO management master top: joins the register file, the MDC
// divider and the frame serialiser. Assumes an external tri-state pad
// combines mdio_o/mdio_oe and returns the line on mdio_i.
module mdio_mgmt_master
    import mdio_pkg::*;
#(
    parameter int               DIV_W   = 8,
    parameter logic [DIV_W-1:0] DIV_RST = 8'd4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    output logic              mdc,
    output logic              mdio_o,
    output logic              mdio_oe,
    input  logic              mdio_i,
    output logic              irq
);
    mdio_cmd_t         cmd;
    logic              busy;
    logic              frame_done;
    logic              cmd_accept;
    logic [DIV_W-1:0]  half;
    logic [DATA_W-1:0] rd_bits;
    logic              rise_tick;
    logic              fall_tick;
    logic              cause_bit;
    logic              mask_bit;

    mdio_regs #(.DIV_W(DIV_W), .DIV_RST(DIV_RST)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata),
        .busy(busy), .done(frame_done), .rd_bits(rd_bits),
        .accept(cmd_accept), .cmd(cmd), .half(half),
        .cause_bit(cause_bit), .mask_bit(mask_bit), .irq(irq)
    );

    mdio_clkgen #(.DIV_W(DIV_W)) u_clk (
        .clk(clk), .rst_n(rst_n), .run(busy), .half(half),
        .mdc(mdc), .rise_tick(rise_tick), .fall_tick(fall_tick)
    );

    mdio_shifter u_shift (
        .clk(clk), .rst_n(rst_n),
        .load(cmd_accept),
        .cmd(mdio_cmd_t'({reg_wdata[POS_OP],
                          reg_wdata[POS_PHY +: FIELD_W],
                          reg_wdata[POS_REG +: FIELD_W],
                          reg_wdata[POS_DATA +: DATA_W]})),
        .rise_tick(rise_tick), .fall_tick(fall_tick),
        .mdio_i(mdio_i), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
        .active(busy), .done(frame_done), .rd_bits(rd_bits)
    );
endmodule

// File: rtl/mdio_mgmt_master_chk.sv
`timescale 1ns/1ps
// Property checker for the MDIO management master, bound to the top.
module mdio_mgmt_master_chk (
    input logic clk,
    input logic rst_n,
    input logic busy,
    input logic frame_done,
    input logic cmd_accept,
    input logic mdc,
    input logic mdio_o,
    input logic cause_bit,
    input logic mask_bit,
    input logic irq
);
    // R2
    start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_accept |=> busy);
    // R7
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !frame_done) |=> busy);
    // R6
    mdc_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mdc);
    // R3
    mdio_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mdc) |-> $stable(mdio_o));
    // R8
    cause_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> cause_bit);
    // R9
    irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mask_bit |-> !irq);
endmodule

bind mdio_mgmt_master mdio_mgmt_master_chk u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .frame_done(frame_done),
    .cmd_accept(cmd_accept), .mdc(mdc), .mdio_o(mdio_o),
    .cause_bit(cause_bit), .mask_bit(mask_bit), .irq(irq)
);

// File: tb/tb_mdio_mgmt_master.sv
`timescale 1ns/1ps
module tb_mdio_mgmt_master;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = 8'h00;
    logic [31:0] reg_wdata = 32'h0;
    logic [31:0] reg_rdata;
    logic        mdc, mdio_o, mdio_oe, irq;
    logic        mdio_i = 1'b1;

    always #2.5 clk = ~clk;

    mdio_mgmt_master dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i), .irq(irq)
    );

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    bit finished = 0;

    always @(posedge clk) cyc++;

    // PHY model: records each rising MDC, answers reads after falling MDC
    int          cap_n = 0;
    logic [63:0] cap_o, cap_oe;
    logic [15:0] phy_val = 16'h0;
    int          t_rise0, t_fall0, t_rise1;

    always @(posedge mdc) begin
        if (cap_n == 0) t_rise0 = cyc;
        if (cap_n == 1) t_rise1 = cyc;
        if (cap_n < 64) begin
            cap_o[63-cap_n]  = mdio_o;
            cap_oe[63-cap_n] = mdio_oe;
        end
        cap_n++;
    end

    always @(negedge mdc) begin
        if (cap_n == 1) t_fall0 = cyc;
        mdio_i = (cap_n >= 48 && cap_n < 64) ? phy_val[63-cap_n] : 1'b1;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic wait_idle();
        logic [31:0] s;
        for (int i = 0; i < 20000; i++) begin
            rd(8'h00, s);
            if (!s[28]) break;
        end
    endtask

    function automatic logic [31:0] cmd_word(bit r, logic [4:0] p, logic [4:0] g,
                                             logic [15:0] v);
        return {5'b0, r, g, p, (r ? 16'h0 : v)};
    endfunction

    // one full transaction with frame, status and cause checks
    task automatic run_cmd(input bit r, input logic [4:0] p, input logic [4:0] g,
                           input logic [15:0] v);
        logic [31:0] s;
        logic [63:0] exp_f, exp_oe;
        cap_n   = 0;
        phy_val = v;
        wr(8'h00, cmd_word(r, p, g, v));
        rd(8'h00, s);
        check(s[28] == 1'b1, "R2", "busy after start", s[28], 1);
        wait_idle();
        exp_f  = {32'hFFFF_FFFF, 2'b01, (r ? 2'b10 : 2'b01), p, g, 2'b10, v};
        exp_oe = r ? {{46{1'b1}}, 18'h0} : {64{1'b1}};
        check(cap_n == 64, "R6", "rising MDC count", cap_n, 64);
        check(cap_oe == exp_oe, r ? "R4" : "R3", "oe pattern", cap_oe, exp_oe);
        check((cap_o & exp_oe) == (exp_f & exp_oe), r ? "R4" : "R3", "frame bits",
              cap_o & exp_oe, exp_f & exp_oe);
        rd(8'h00, s);
        check(s[27] == r, "R5", "read-valid", s[27], r);
        check(s[15:0] == v, "R5", "data field", s[15:0], v);
        check(s[20:16] == p && s[25:21] == g, "R3", "address fields",
              s[25:16], {g, p});
        rd(8'h7C, s);
        check(s == 32'h10, "R8", "cause after frame", s, 32'h10);
    endtask

    task automatic clear_cause();
        logic [31:0] s;
        wr(8'h7C, 32'hFFFF_FFFF);
        rd(8'h7C, s);
        check(s == 32'h10, "R8", "cause kept by writing one", s, 32'h10);
        wr(8'h7C, 32'hFFFF_FFEF);
        rd(8'h7C, s);
        check(s == 32'h0, "R8", "cause cleared by zero", s, 0);
    endtask

    // watchdog
    always @(posedge clk) begin
        if (cyc == 150000 && !finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog run did not finish actual=%0d expected=<150000", cyc);
            $display("[TB] %0d tests run, %0d failed", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] s;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(8'h00, s); check(s == 0, "R1", "command word", s, 0);
        rd(8'h7C, s); check(s == 0, "R1", "cause", s, 0);
        rd(8'h80, s); check(s == 0, "R1", "mask", s, 0);
        rd(8'h04, s); check(s == 4, "R1", "divider", s, 4);
        check(mdc == 0 && mdio_oe == 0 && irq == 0, "R1", "idle pins",
              {mdc, mdio_oe, irq}, 0);

        // sweep all PHY addresses, alternating writes and reads
        wr(8'h04, 32'd2);
        for (int p = 0; p < 32; p++) begin
            run_cmd(p[0], 5'(p), 5'((p * 7 + 3) % 32),
                    16'((p * 16'h00F1) ^ 16'hA5C3));
            clear_cause();
        end

        // divider sweep, including zero treated as one
        for (int k = 0; k < 4; k++) begin
            int d, e;
            d = (k == 3) ? 0 : 2 * k + 1;
            e = (d == 0) ? 1 : d;
            wr(8'h04, 32'(d));
            run_cmd(1'b0, 5'(k + 9), 5'(31 - k), 16'(16'h1357 + k));
            check(t_fall0 - t_rise0 == e, "R6", "MDC high width", t_fall0 - t_rise0, e);
            check(t_rise1 - t_fall0 == e, "R6", "MDC low width", t_rise1 - t_fall0, e);
            clear_cause();
        end

        // R7: overlapping command is dropped
        wr(8'h04, 32'd2);
        cap_n = 0;
        wr(8'h00, cmd_word(1'b0, 5'd5, 5'd9, 16'h1234));
        repeat (20) @(negedge clk);
        wr(8'h00, cmd_word(1'b1, 5'd17, 5'd2, 16'h0));
        rd(8'h00, s);
        check(s[26:16] == {1'b0, 5'd9, 5'd5}, "R7", "command kept while busy",
              s[26:16], {1'b0, 5'd9, 5'd5});
        wait_idle();
        check(cap_o == {32'hFFFF_FFFF, 2'b01, 2'b01, 5'd5, 5'd9, 2'b10, 16'h1234},
              "R7", "frame unaffected", cap_o,
              {32'hFFFF_FFFF, 2'b01, 2'b01, 5'd5, 5'd9, 2'b10, 16'h1234});
        clear_cause();

        // R5: read-valid drops on the next accepted command
        run_cmd(1'b1, 5'd3, 5'd7, 16'hBEEF);
        clear_cause();
        wr(8'h00, cmd_word(1'b0, 5'd1, 5'd1, 16'h0001));
        rd(8'h00, s);
        check(s[27] == 0 && s[28] == 1, "R5", "read-valid cleared on accept",
              s[28:27], 2'b10);
        wait_idle();
        clear_cause();

        // R9: masking of the completion interrupt
        run_cmd(1'b0, 5'd30, 5'd30, 16'h0F0F);
        @(negedge clk);
        check(irq == 0, "R9", "irq masked", irq, 0);
        wr(8'h80, 32'h10);
        rd(8'h80, s);
        check(s == 32'h10, "R9", "mask readback", s, 32'h10);
        check(irq == 1, "R9", "irq unmasked", irq, 1);
        wr(8'h7C, 32'h0);
        @(negedge clk);
        check(irq == 0, "R9", "irq after cause clear", irq, 0);
        wr(8'h80, 32'h0);
        rd(8'h80, s);
        check(s == 32'h0, "R9", "mask disabled", s, 0);

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end
endmodule